// File: doc/BRIEF.md
# Console Register Display and Entry Selector

This block sits behind a programmer's front panel. It chooses one processor register and shows its contents on a 16-bit display word. It also lets an operator load the value on the data switches into the chosen register with the ENTER key. The registers are held in a small internal register file. Sixteen entries are addressed by a 4-bit index: four entries are reached through dedicated direct-select switches, and twelve general registers are reached through an encoded 4-bit select code.

The four direct-select switches (operation, buffer, memory-data and memory-address) follow a fixed priority. When any of them is active, it overrides the encoded select code. Only the operation and buffer targets can be written. Every accepted ENTER also loads the same data into the buffer entry. The console-enable input gates ENTER and the direct-select switches. The data switches and the encoded select code work whatever its level. ENTER is edge-detected, so one press causes at most one write, and the block reports each write through a strobe, a target index and a buffer-copy strobe.

Top module: `console_regsel`

## Requirements
- R1: Every switch input reads 1 for the down position and 0 for the up position. A written register receives `data_sw` bit for bit, with no inversion.
- R2: With all direct-select switches inactive, a select code of 4 to 15 picks general register 4 to 15, in the order A, Q, CAR1, SCR1, CAR2, SCR2, CAR3, SCR3, CAR4, SCR4, CAR5, SCR5. The display shows that register, and a write reports `wr_idx` equal to the code.
- R3: The direct-select switches rank operation > buffer > memory-data > memory-address, with target indices 0, 1, 2 and 3. The highest-ranked active switch wins, and the others have no effect.
- R4: The encoded select code is used only when no direct-select switch is in effect. Otherwise the code does not change the display or the write target.
- R5: The memory-data and memory-address targets (indices 2 and 3) can only be displayed. ENTER while one of them is selected produces no strobe and changes no register, including the buffer.
- R6: An accepted ENTER writes `data_sw` into the buffer entry (index 1) on the same clock edge as the target. `bcopy_stb` pulses together with `wr_stb` whenever the target is not the buffer itself, and stays low when it is.
- R7: While `console_en` is low, ENTER and the four direct-select switches are ignored. The encoded select code still drives the display.
- R8: Select codes 0 to 3 with no direct-select switch in effect choose no register. The display reads zero and ENTER does nothing.
- R9: A rising edge of `enter_sw` that is accepted gives exactly one `wr_stb` pulse, one cycle long, in the cycle after the edge is sampled, however long the key is held.
- R10: After a synchronous active-low reset, every register reads zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| console_en | input | 1 | Console enable; gates ENTER and direct selection |
| sw_o | input | 1 | Direct select, operation register (highest priority) |
| sw_b | input | 1 | Direct select, buffer register |
| sw_m | input | 1 | Direct select, memory-data register |
| sw_l | input | 1 | Direct select, memory-address register (lowest priority) |
| reg_sel | input | 4 | Encoded register select code |
| data_sw | input | 16 | Data switches |
| enter_sw | input | 1 | ENTER key level |
| disp_word | output | 16 | Contents of the selected register, zero if none |
| wr_stb | output | 1 | One-cycle pulse per accepted write |
| wr_idx | output | 4 | Index of the register written, valid with `wr_stb` |
| bcopy_stb | output | 1 | Pulse marking the copy into the buffer entry |

## Verification
`disp_word` is combinational from the switch positions and the stored registers. The bench therefore checks it one time unit after changing a select input, with no clock edge in between. A press is applied just after a falling edge. The edge detector and the register file both act on the next rising edge, so `wr_stb`, `wr_idx`, `bcopy_stb` and the new register contents are due one cycle after the press. The bench samples them at the following falling edge, and samples again one cycle later to confirm that the strobe has dropped. After every press, the bench briefly selects the buffer entry and compares it against a model that the bench computes from the priority and gating rules.

// File: rtl/console_pkg.sv
// Package: console_pkg
// Purpose : shared index assignments and the direct-select switch bundle for
//           the console register selector.
// Assumes : the direct targets occupy the low four indices of the register
//           file, which the encoded select code never reaches.
package console_pkg;

    // Register-file index of each direct-select target; order equals priority.
    localparam int unsigned IDX_OPER = 0;
    localparam int unsigned IDX_BUFF = 1;
    localparam int unsigned IDX_MDAT = 2;
    localparam int unsigned IDX_MADR = 3;

    // First encoded select code that names a real register.
    localparam int unsigned FIRST_CODE = 4;

    // Bundle of the four direct-select switches, highest priority first.
    typedef struct packed {
        logic oper;
        logic buff;
        logic mdat;
        logic madr;
    } dsel_t;

endpackage

// File: rtl/console_sel_decode.sv
// Module : console_sel_decode
// Purpose: resolves the interlocked direct-select switches and the encoded
//          select code into a single register-file index, and classifies the
//          target as displayable and/or writable.
// Assumes: switch inputs are already clean levels; console_en gates only the
//          direct switches, never the encoded code.
module console_sel_decode
    import console_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic             console_en,
    input  dsel_t            dsel,
    input  logic [SEL_W-1:0] reg_sel,
    output logic [SEL_W-1:0] tgt_idx,
    output logic             tgt_valid,
    output logic             tgt_writable
);

    localparam logic [SEL_W-1:0] FIRST_C = SEL_W'(FIRST_CODE);

    logic  direct_any;
    dsel_t eff;

    // Gate the direct switches with console enable.
    always_comb begin
        eff        = console_en ? dsel : '0;
        direct_any = eff.oper | eff.buff | eff.mdat | eff.madr;
    end

    // Priority resolution: operation, buffer, memory data, memory address, code.
    always_comb begin
        tgt_idx      = '0;
        tgt_valid    = 1'b0;
        tgt_writable = 1'b0;
        if (eff.oper) begin
            tgt_idx      = SEL_W'(IDX_OPER);
            tgt_valid    = 1'b1;
            tgt_writable = 1'b1;
        end else if (eff.buff) begin
            tgt_idx      = SEL_W'(IDX_BUFF);
            tgt_valid    = 1'b1;
            tgt_writable = 1'b1;
        end else if (eff.mdat) begin
            tgt_idx      = SEL_W'(IDX_MDAT);
            tgt_valid    = 1'b1;
        end else if (eff.madr) begin
            tgt_idx      = SEL_W'(IDX_MADR);
            tgt_valid    = 1'b1;
        end else if (!direct_any && reg_sel >= FIRST_C) begin
            tgt_idx      = reg_sel;
            tgt_valid    = 1'b1;
            tgt_writable = 1'b1;
        end
    end

endmodule

// File: rtl/console_enter_edge.sv
// Module : console_enter_edge
// Purpose: turns the ENTER key level into a one-cycle request on its rising
//          edge, accepted only while the console is enabled.
// Assumes: enter_sw is already synchronous to clk and debounced.
module console_enter_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic console_en,
    input  logic enter_sw,
    output logic enter_rise
);

    logic enter_q;

    // Remember the previous key level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) enter_q <= 1'b0;
        else        enter_q <= enter_sw;
    end

    // A request exists only on a fresh press with the console enabled.
    always_comb enter_rise = enter_sw & ~enter_q & console_en;

endmodule

// File: rtl/console_regfile.sv
// Module : console_regfile
// Purpose: the register file behind the console: one write port that also
//          copies into the buffer entry, one combinational read port.
// Assumes: the write index never names a read-only entry; read-only entries
//          are built without write logic and keep their reset value here.
module console_regfile
    import console_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rvalid,
    input  logic [SEL_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned NREG = 2 ** SEL_W;

    logic [NREG-1:0][DATA_W-1:0] rd_bus;

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic [DATA_W-1:0] q;
        if (i == IDX_MDAT || i == IDX_MADR) begin : g_ro
            // Display-only entry: holds its reset value.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
            end
        end else if (i == IDX_BUFF) begin : g_buf
            // Buffer entry: loaded by every accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= '0;
                else if (we) q <= wdata;
            end
        end else begin : g_rw
            // Ordinary entry: loaded when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                               q <= '0;
                else if (we && widx == SEL_W'(i))         q <= wdata;
            end
        end
        assign rd_bus[i] = q;
    end

    // Read port: zero when nothing is selected.
    always_comb rdata = rvalid ? rd_bus[ridx] : '0;

endmodule

// File: rtl/console_regsel.sv
// Module : console_regsel
// Purpose: top of the console register display and entry selector. Routes
//          the selected register to the display and performs ENTER writes
//          with the buffer copy, reporting each write through strobes.
// Assumes: all inputs synchronous to clk; switch value 1 means down/on.
module console_regsel
    import console_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              console_en,
    input  logic              sw_o,
    input  logic              sw_b,
    input  logic              sw_m,
    input  logic              sw_l,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] data_sw,
    input  logic              enter_sw,
    output logic [DATA_W-1:0] disp_word,
    output logic              wr_stb,
    output logic [SEL_W-1:0]  wr_idx,
    output logic              bcopy_stb
);

    dsel_t            dsel;
    logic [SEL_W-1:0] tgt_idx;
    logic             tgt_valid;
    logic             tgt_writable;
    logic             enter_rise;
    logic             do_write;

    // Bundle the direct-select switches in priority order.
    always_comb dsel = '{oper: sw_o, buff: sw_b, mdat: sw_m, madr: sw_l};

    console_sel_decode #(.SEL_W(SEL_W)) u_decode (
        .console_en  (console_en),
        .dsel        (dsel),
        .reg_sel     (reg_sel),
        .tgt_idx     (tgt_idx),
        .tgt_valid   (tgt_valid),
        .tgt_writable(tgt_writable)
    );

    console_enter_edge u_enter (
        .clk       (clk),
        .rst_n     (rst_n),
        .console_en(console_en),
        .enter_sw  (enter_sw),
        .enter_rise(enter_rise)
    );

    // A write happens on a fresh press aimed at a writable target.
    always_comb do_write = enter_rise & tgt_writable;

    console_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_write),
        .widx  (tgt_idx),
        .wdata (data_sw),
        .rvalid(tgt_valid),
        .ridx  (tgt_idx),
        .rdata (disp_word)
    );

    // Report each write one cycle after the press, together with the copy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb    <= 1'b0;
            wr_idx    <= '0;
            bcopy_stb <= 1'b0;
        end else begin
            wr_stb    <= do_write;
            bcopy_stb <= do_write && (tgt_idx != SEL_W'(IDX_BUFF));
            if (do_write) wr_idx <= tgt_idx;
        end
    end

endmodule

// File: rtl/console_regsel_chk.sv
// Module : console_regsel_chk
// Purpose: property checker for console_regsel, attached with bind.
// Assumes: sees only the top-level ports of the selector.
module console_regsel_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              console_en,
    input logic              sw_o,
    input logic              sw_b,
    input logic              sw_m,
    input logic              sw_l,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [DATA_W-1:0] data_sw,
    input logic              enter_sw,
    input logic [DATA_W-1:0] disp_word,
    input logic              wr_stb,
    input logic [SEL_W-1:0]  wr_idx,
    input logic              bcopy_stb
);

    // R9: a strobe never lasts two cycles.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6: the copy strobe only accompanies a write strobe, never for the buffer target.
    a_r6_bcopy_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        bcopy_stb |-> (wr_stb && wr_idx != SEL_W'(1)));

    // R5: display-only targets are never written.
    a_r5_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx != SEL_W'(2) && wr_idx != SEL_W'(3)));

    // R7: no write is reported for a cycle in which the console was disabled.
    a_r7_disabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(console_en) |-> !wr_stb);

    // R8: nothing selected means a zero display.
    a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!(console_en && (sw_o || sw_b || sw_m || sw_l)) && reg_sel < SEL_W'(4))
            |-> disp_word == '0);

    // R6: the buffer shows the entered data right after a write.
    a_r6_buffer_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && console_en && sw_b && !sw_o) |-> disp_word == $past(data_sw));

endmodule

bind console_regsel console_regsel_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/console_regsel_bench.sv
module console_regsel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        console_en = 1'b0;
    logic        sw_o = 1'b0, sw_b = 1'b0, sw_m = 1'b0, sw_l = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] data_sw = '0;
    logic        enter_sw = 1'b0;
    logic [15:0] disp_word;
    logic        wr_stb;
    logic [3:0]  wr_idx;
    logic        bcopy_stb;

    int tests = 0;
    int fails = 0;
    logic [15:0] model [16];

    always #2 clk = ~clk;

    console_regsel u_console_regsel (
        .clk(clk), .rst_n(rst_n), .console_en(console_en),
        .sw_o(sw_o), .sw_b(sw_b), .sw_m(sw_m), .sw_l(sw_l),
        .reg_sel(reg_sel), .data_sw(data_sw), .enter_sw(enter_sw),
        .disp_word(disp_word), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .bcopy_stb(bcopy_stb)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected target from the priority and gating rules; -1 means none.
    function automatic int tgt_of(bit en, bit o, bit b, bit m, bit l, int s);
        if (en && o) return 0;
        if (en && b) return 1;
        if (en && m) return 2;
        if (en && l) return 3;
        if (s >= 4)  return s;
        return -1;
    endfunction

    task automatic set_sel(bit en, bit o, bit b, bit m, bit l, int s);
        console_en = en; sw_o = o; sw_b = b; sw_m = m; sw_l = l;
        reg_sel = 4'(s);
    endtask

    // Press ENTER with the given selection and value, then check everything.
    task automatic press(bit en, bit o, bit b, bit m, bit l, int s,
                         logic [15:0] v, int hold);
        int  t;
        bit  wr;
        int  pulses;
        t  = tgt_of(en, o, b, m, l, s);
        wr = en && (t == 0 || t == 1 || t >= 4);
        @(negedge clk);
        set_sel(en, o, b, m, l, s);
        data_sw  = v;
        enter_sw = 1'b1;
        @(negedge clk);
        if (wr) begin
            model[t] = v;
            model[1] = v;
        end
        chk(wr ? "R9" : (!en ? "R7" : (t < 0 ? "R8" : "R5")), "wr_stb",
            32'(wr_stb), 32'(wr));
        if (wr) begin
            chk(t < 4 ? "R3" : "R2", "wr_idx", 32'(wr_idx), 32'(t));
            chk("R6", "bcopy_stb", 32'(bcopy_stb), 32'(t != 1));
        end else begin
            chk("R6", "bcopy_stb idle", 32'(bcopy_stb), 32'(0));
        end
        chk(t < 0 ? "R8" : (t >= 4 ? "R4" : "R3"), "disp_word",
            32'(disp_word), 32'(t < 0 ? 16'h0 : model[t]));
        pulses = 0;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (wr_stb) pulses++;
        end
        enter_sw = 1'b0;
        @(negedge clk);
        if (wr_stb) pulses++;
        chk("R9", "extra pulses", 32'(pulses), 32'(0));
        set_sel(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        #1;
        chk("R6", "buffer contents", 32'(disp_word), 32'(model[1]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) model[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state.
        chk("R10", "wr_stb in reset", 32'(wr_stb), 32'(0));
        chk("R10", "bcopy in reset", 32'(bcopy_stb), 32'(0));
        rst_n = 1'b1;
        for (int s = 0; s < 16; s++) begin
            set_sel(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, s);
            #1;
            chk("R10", "register after reset", 32'(disp_word), 32'(0));
        end
        // R1: exact bit pattern, including all-ones and all-zeros.
        press(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 16'hFFFF, 0);
        press(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 16'h8001, 0);
        press(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 16'h0000, 0);
        // R9: a long hold yields one strobe.
        press(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6, 16'h1234, 6);
        press(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9, 16'hA5C3, 4);
        // R2/R3/R4/R5/R6/R7/R8: sweep enable, all direct patterns, all codes.
        for (int en = 0; en < 2; en++) begin
            for (int d = 0; d < 16; d++) begin
                for (int s = 0; s < 16; s++) begin
                    logic [15:0] v;
                    v = 16'((en * 16'h9E37) ^ (d * 16'h0F1D) ^ (s * 16'h3B01) ^ 16'h5A5A);
                    press(en[0], d[3], d[2], d[1], d[0], s, v, 0);
                end
            end
        end
        // R2: final readback of every encoded register by code.
        for (int s = 4; s < 16; s++) begin
            @(negedge clk);
            set_sel(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, s);
            #1;
            chk("R2", "readback by code", 32'(disp_word), 32'(model[s]));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule